// File: doc/BRIEF.md
# BAR-Routed Register Responder

This block sits behind a PCIe transaction-layer receive path that has already decoded which base-address window a memory request falls into. Each request arrives as a single 128-bit header beat with a one-hot window-hit vector and a 32-bit write payload on a side lane. The block keeps a small bank of 32-bit registers behind every window. A memory write updates the addressed register under its first byte enables and sends nothing back. A memory read returns a single completion-with-data beat on a 128-bit output stream. That completion carries the register value and copies the requester's ID and tag from the request.

Both streams use valid/ready handshakes. The block holds at most one completion at a time, and it refuses new requests while a completion waits at the output. Requests it does not understand are accepted and discarded without any effect: other TLP types, lengths other than one DW, or a hit vector with no bit set.

Top module: `bar_reg_responder`

## Requirements
- R1: After reset, cpl_valid is 0, req_ready is 1 and every register in every window reads as zero.
- R2: An accepted write (fmt/type byte req_data[31:24] = 0x40, length req_data[9:0] = 1) stores req_wdata into register (offset >> 2) of the selected window and raises no completion.
- R3: A write changes only the bytes whose bit is set in the first byte enables req_data[35:32] (bit k covers data bits 8k+7..8k). The other bytes keep their old value.
- R4: An accepted read (fmt/type 0x00, length 1) raises cpl_valid on the clock edge that accepts it. The completion is DW0 = 0x4A000001 in bits [31:0], DW1 = {completer ID (default 0x0100), 16'h0004} in bits [63:32], and the register value in bits [127:96].
- R5: Completion DW2 (bits [95:64]) holds the requester ID from req_data[63:48] in [31:16], the tag from req_data[47:40] in [15:8], and request address bits [6:0] in [6:0].
- R6: When several hit bits are set, the lowest-numbered set bit selects the window.
- R7: The register offset is the request address masked to the window size (default 4 KB). Address bits above the window have no effect.
- R8: A read of an offset with no register behind it returns 0 (default four registers, offsets 0x0 to 0xC). A write to such an offset changes no register.
- R9: The 4DW forms (read 0x20, write 0x60) take the low address from req_data[127:96]. The 3DW forms take it from req_data[95:64].
- R10: A request is dropped with no completion and no register change when any of these holds: its fmt/type is not one of the four above, its length is not 1, or it hits no window.
- R11: While a completion waits, req_ready is 0 and cpl_data stays unchanged until cpl_ready takes the completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request beat valid |
| req_ready | output | 1 | Block can take a request |
| req_data | input | 128 | Request header DW0..DW3, DW0 in bits [31:0] |
| req_hit | input | NUM_BARS | One-hot window hit vector |
| req_wdata | input | 32 | Write payload |
| cpl_valid | output | 1 | Completion beat valid |
| cpl_ready | input | 1 | Downstream takes the completion |
| cpl_data | output | 128 | Completion DW0..DW3, DW0 in bits [31:0] |

## Verification
Full-word writes followed by reads in two windows show that the windows are separate and that the completion fields are built correctly. Partial byte enables over a known value reveal a lane swap or an ignored enable. Hit vectors with two bits set, addresses with high bits set, 4DW headers and offsets past the last register each target one decode step: priority, masking, address word selection and the bounds guard. A readback after every dropped or blocked request shows that it left no trace. Holding off cpl_ready checks that the completion stays stable and that intake stops.

// File: rtl/rr_pkg.sv
package rr_pkg;

  localparam logic [7:0] FT_RD3 = 8'h00;
  localparam logic [7:0] FT_RD4 = 8'h20;
  localparam logic [7:0] FT_WR3 = 8'h40;
  localparam logic [7:0] FT_WR4 = 8'h60;
  localparam logic [7:0] FT_CPLD = 8'h4A;

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic [31:0] addr;
    logic [15:0] rid;
    logic [7:0]  tag;
    logic [3:0]  fbe;
  } req_info_t;

  function automatic req_info_t decode_req(input logic [127:0] h);
    req_info_t   d;
    logic [7:0]  ft;
    logic        one_dw;
    ft     = h[31:24];
    one_dw = (h[9:0] == 10'd1);
    d.rd   = one_dw && (ft == FT_RD3 || ft == FT_RD4);
    d.wr   = one_dw && (ft == FT_WR3 || ft == FT_WR4);
    d.addr = ft[5] ? h[127:96] : h[95:64];
    d.rid  = h[63:48];
    d.tag  = h[47:40];
    d.fbe  = h[35:32];
    return d;
  endfunction

endpackage

// File: rtl/rr_bar_pick.sv
module rr_bar_pick #(
  parameter int NUM_BARS = 2,
  localparam int SEL_W = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
  input  logic [NUM_BARS-1:0] hit,
  output logic [SEL_W-1:0]    sel,
  output logic                any
);

  generate
    if (NUM_BARS == 1) begin : g_single
      assign sel = '0;
      assign any = hit[0];
    end else begin : g_multi
      always_comb begin
        sel = '0;
        for (int i = NUM_BARS - 1; i >= 0; i--) begin
          if (hit[i]) sel = SEL_W'(i);
        end
      end
      assign any = |hit;
    end
  endgenerate

endmodule

// File: rtl/rr_reg_file.sv
module rr_reg_file #(
  parameter int NUM_BARS = 2,
  parameter int NUM_REGS = 4,
  localparam int SEL_W = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] bar,
  input  logic [IDX_W-1:0] idx,
  input  logic [3:0]       wbe,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);

  logic [31:0] mem [NUM_BARS][NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NUM_BARS; b++)
        for (int r = 0; r < NUM_REGS; r++)
          mem[b][r] <= '0;
    end else if (we) begin
      for (int k = 0; k < 4; k++)
        if (wbe[k]) mem[bar][idx][8*k +: 8] <= wdata[8*k +: 8];
    end
  end

  assign rdata = mem[bar][idx];

endmodule

// File: rtl/rr_cpl_out.sv
module rr_cpl_out #(
  parameter logic [15:0] CPL_ID = 16'h0100
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         take,
  input  logic [15:0]  rid,
  input  logic [7:0]   tag,
  input  logic [6:0]   low_addr,
  input  logic [31:0]  value,
  output logic         valid,
  output logic [127:0] data
);

  logic [31:0] dw0, dw1, dw2;

  assign dw0 = {rr_pkg::FT_CPLD, 14'd0, 10'd1};
  assign dw1 = {CPL_ID, 3'b000, 1'b0, 12'd4};
  assign dw2 = {rid, tag, 1'b0, low_addr};

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= {value, dw2, dw1, dw0};
    end else if (take) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/bar_reg_responder.sv
module bar_reg_responder #(
  parameter int          NUM_BARS = 2,
  parameter int          NUM_REGS = 4,
  parameter int          WIN_LOG2 = 12,
  parameter logic [15:0] CPL_ID   = 16'h0100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [127:0]        req_data,
  input  logic [NUM_BARS-1:0] req_hit,
  input  logic [31:0]         req_wdata,
  output logic                cpl_valid,
  input  logic                cpl_ready,
  output logic [127:0]        cpl_data
);

  localparam int SEL_W  = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1;
  localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int WORD_W = WIN_LOG2 - 2;

  rr_pkg::req_info_t info;
  logic              accept;
  logic [SEL_W-1:0]  sel;
  logic              any_hit;
  logic [WORD_W-1:0] word;
  logic              mapped;
  logic [IDX_W-1:0]  idx;
  logic [31:0]       file_rd;
  logic [31:0]       rd_value;
  logic              unused_hi;

  assign info      = rr_pkg::decode_req(req_data);
  assign req_ready = !cpl_valid;
  assign accept    = req_valid && req_ready;

  rr_bar_pick #(.NUM_BARS(NUM_BARS)) u_pick (
    .hit (req_hit),
    .sel (sel),
    .any (any_hit)
  );

  assign word      = info.addr[WIN_LOG2-1:2];
  assign mapped    = 32'(word) < 32'(NUM_REGS);
  assign idx       = word[IDX_W-1:0];
  assign unused_hi = ^{info.addr[31:WIN_LOG2]};

  rr_reg_file #(.NUM_BARS(NUM_BARS), .NUM_REGS(NUM_REGS)) u_file (
    .clk   (clk),
    .rst   (rst),
    .we    (accept && info.wr && any_hit && mapped),
    .bar   (sel),
    .idx   (idx),
    .wbe   (info.fbe),
    .wdata (req_wdata),
    .rdata (file_rd)
  );

  assign rd_value = mapped ? file_rd : 32'h0;

  rr_cpl_out #(.CPL_ID(CPL_ID)) u_cpl (
    .clk      (clk),
    .rst      (rst),
    .load     (accept && info.rd && any_hit),
    .take     (cpl_ready),
    .rid      (info.rid),
    .tag      (info.tag),
    .low_addr (info.addr[6:0]),
    .value    (rd_value),
    .valid    (cpl_valid),
    .data     (cpl_data)
  );

endmodule

// File: rtl/rr_checker.sv
module rr_checker #(
  parameter int NUM_BARS = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_ready,
  input logic [127:0]        req_data,
  input logic [NUM_BARS-1:0] req_hit,
  input logic                cpl_valid,
  input logic                cpl_ready,
  input logic [127:0]        cpl_data
);

  logic rd_acc, wr_acc, unused_chk;
  assign unused_chk = ^req_data;
  assign rd_acc = req_valid && req_ready && |req_hit && req_data[9:0] == 10'd1 &&
                  (req_data[31:24] == 8'h00 || req_data[31:24] == 8'h20);
  assign wr_acc = req_valid && req_ready && |req_hit && req_data[9:0] == 10'd1 &&
                  (req_data[31:24] == 8'h40 || req_data[31:24] == 8'h60);

  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !cpl_valid)
    else $error("R1 completion valid after reset");

  a_r4_latency: assert property (@(posedge clk) disable iff (rst) rd_acc |=> cpl_valid)
    else $error("R4 read gave no completion");

  a_r4_shape: assert property (@(posedge clk) disable iff (rst)
    cpl_valid |-> (cpl_data[31:24] == 8'h4A && cpl_data[9:0] == 10'd1 && cpl_data[43:32] == 12'd4))
    else $error("R4 completion header malformed");

  a_r5_echo: assert property (@(posedge clk) disable iff (rst)
    rd_acc |=> (cpl_data[95:80] == $past(req_data[63:48]) && cpl_data[79:72] == $past(req_data[47:40])))
    else $error("R5 requester ID or tag not echoed");

  a_r2_write_silent: assert property (@(posedge clk) disable iff (rst) wr_acc |=> !cpl_valid)
    else $error("R2 write produced a completion");

  a_r11_ready_blocked: assert property (@(posedge clk) disable iff (rst) cpl_valid |-> !req_ready)
    else $error("R11 ready high with completion pending");

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_data)))
    else $error("R11 completion changed while stalled");

endmodule

bind bar_reg_responder rr_checker #(.NUM_BARS(NUM_BARS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_data  (req_data),
  .req_hit   (req_hit),
  .cpl_valid (cpl_valid),
  .cpl_ready (cpl_ready),
  .cpl_data  (cpl_data)
);

// File: tb/sim_bar_reg_responder.sv
module sim_bar_reg_responder;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [127:0] req_data = '0;
  logic [1:0]   req_hit = '0;
  logic [31:0]  req_wdata = '0;
  logic         cpl_valid;
  logic         cpl_ready = 1'b0;
  logic [127:0] cpl_data;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  bar_reg_responder u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .req_hit(req_hit), .req_wdata(req_wdata),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_data(cpl_data)
  );

  task automatic chk(input string r, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] ft, input logic [9:0] len, input logic [1:0] hit,
                      input logic [31:0] ahi, input logic [31:0] alo, input logic [3:0] be,
                      input logic [15:0] rid, input logic [7:0] tag, input logic [31:0] wd);
    @(negedge clk);
    if (ft[5]) req_data = {alo, ahi, rid, tag, 4'h0, be, ft, 14'd0, len};
    else       req_data = {32'h0, alo, rid, tag, 4'h0, be, ft, 14'd0, len};
    req_hit   = hit;
    req_wdata = wd;
    req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic take();
    cpl_ready = 1'b1;
    @(posedge clk);
    #1 cpl_ready = 1'b0;
  endtask

  task automatic wr(input logic [1:0] hit, input logic [31:0] addr, input logic [3:0] be,
                    input logic [31:0] d, input string r);
    send(8'h40, 10'd1, hit, 32'h0, addr, be, 16'h0, 8'h0, d);
    chk({r, " write gives no completion"}, cpl_valid, 0);
  endtask

  task automatic rd(input logic [1:0] hit, input logic [31:0] addr, input bit four,
                    input logic [31:0] exp, input string r);
    send(four ? 8'h20 : 8'h00, 10'd1, hit, 32'hFFFF_FFFF, addr, 4'hF, 16'hBEEF, 8'h5A, 32'h0);
    chk({r, " R4 completion valid"}, cpl_valid, 1);
    chk({r, " R4 DW0"}, cpl_data[31:0], 32'h4A00_0001);
    chk({r, " R4 DW1"}, cpl_data[63:32], 32'h0100_0004);
    chk({r, " R5 DW2 echo"}, cpl_data[95:64], {16'hBEEF, 8'h5A, 1'b0, addr[6:0]});
    chk({r, " data"}, cpl_data[127:96], exp);
    take();
    chk({r, " completion taken"}, cpl_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 no completion after reset", cpl_valid, 0);
    rd(2'b01, 32'h0, 0, 32'h0, "R1 BAR0 reg0 zero");
    rd(2'b10, 32'hC, 0, 32'h0, "R1 BAR1 reg3 zero");
  endtask

  task automatic t_write_read();
    wr(2'b01, 32'h0, 4'hF, 32'hDEAD_BEEF, "R2");
    rd(2'b01, 32'h0, 0, 32'hDEAD_BEEF, "R2 BAR0 reg0");
    wr(2'b10, 32'h4, 4'hF, 32'h1122_3344, "R2");
    rd(2'b10, 32'h4, 0, 32'h1122_3344, "R2 BAR1 reg1");
    rd(2'b01, 32'h4, 0, 32'h0, "R2 BAR0 reg1 untouched");
  endtask

  task automatic t_byte_en();
    wr(2'b01, 32'h4, 4'b0101, 32'hAABB_CCDD, "R3");
    rd(2'b01, 32'h4, 0, 32'h00BB_00DD, "R3 lanes 0 and 2");
    wr(2'b01, 32'h4, 4'b1000, 32'h1100_0000, "R3");
    rd(2'b01, 32'h4, 0, 32'h11BB_00DD, "R3 lane 3 merge");
  endtask

  task automatic t_priority();
    wr(2'b11, 32'h8, 4'hF, 32'h0000_0055, "R6");
    rd(2'b01, 32'h8, 0, 32'h55, "R6 BAR0 took write");
    rd(2'b10, 32'h8, 0, 32'h0, "R6 BAR1 untouched");
    rd(2'b11, 32'h8, 0, 32'h55, "R6 double hit read");
  endtask

  task automatic t_window();
    wr(2'b10, 32'hFFFF_F00C, 4'hF, 32'h77, "R7");
    rd(2'b10, 32'h0000_000C, 0, 32'h77, "R7 high bits masked");
    rd(2'b10, 32'h1234_500C, 0, 32'h77, "R7 other high bits");
  endtask

  task automatic t_4dw();
    send(8'h60, 10'd1, 2'b10, 32'hFFFF_FFFF, 32'h8, 4'hF, 16'h0, 8'h0, 32'h99);
    chk("R9 4DW write no completion", cpl_valid, 0);
    rd(2'b10, 32'h8, 1, 32'h99, "R9 4DW read");
    rd(2'b10, 32'h8, 0, 32'h99, "R9 3DW readback");
  endtask

  task automatic t_unmapped();
    rd(2'b01, 32'h10, 0, 32'h0, "R8 offset 0x10");
    rd(2'b01, 32'h7C, 0, 32'h0, "R8 offset 0x7C");
    wr(2'b01, 32'h10, 4'hF, 32'h1234_5678, "R8");
    rd(2'b01, 32'h0, 0, 32'hDEAD_BEEF, "R8 reg0 unchanged");
    rd(2'b01, 32'h10, 0, 32'h0, "R8 still zero");
  endtask

  task automatic t_drop();
    send(8'h40, 10'd2, 2'b01, 32'h0, 32'h0, 4'hF, 16'h0, 8'h0, 32'h0);
    chk("R10 len2 write no completion", cpl_valid, 0);
    send(8'h44, 10'd1, 2'b01, 32'h0, 32'h0, 4'hF, 16'h0, 8'h0, 32'h0);
    chk("R10 bad type no completion", cpl_valid, 0);
    send(8'h40, 10'd1, 2'b00, 32'h0, 32'h0, 4'hF, 16'h0, 8'h0, 32'h0);
    chk("R10 no hit write no completion", cpl_valid, 0);
    send(8'h00, 10'd2, 2'b01, 32'h0, 32'h0, 4'hF, 16'h0, 8'h0, 32'h0);
    chk("R10 len2 read no completion", cpl_valid, 0);
    send(8'h00, 10'd1, 2'b00, 32'h0, 32'h0, 4'hF, 16'h0, 8'h0, 32'h0);
    chk("R10 no hit read no completion", cpl_valid, 0);
    rd(2'b01, 32'h0, 0, 32'hDEAD_BEEF, "R10 reg0 unchanged");
  endtask

  task automatic t_backpressure();
    logic [127:0] snap;
    send(8'h00, 10'd1, 2'b10, 32'h0, 32'h4, 4'hF, 16'hCAFE, 8'h33, 32'h0);
    chk("R11 completion pending", cpl_valid, 1);
    snap = cpl_data;
    chk("R11 pending data", cpl_data[127:96], 32'h1122_3344);
    @(negedge clk);
    req_data  = {32'h0, 32'h0, 16'h0, 8'h0, 4'h0, 4'hF, 8'h40, 14'd0, 10'd1};
    req_hit   = 2'b01;
    req_wdata = 32'h0;
    req_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      #1;
      chk("R11 ready low while stalled", req_ready, 0);
      chk("R11 completion held", cpl_data, snap);
      chk("R11 valid held", cpl_valid, 1);
    end
    req_valid = 1'b0;
    take();
    chk("R11 ready back after take", req_ready, 1);
    rd(2'b01, 32'h0, 0, 32'hDEAD_BEEF, "R11 blocked write had no effect");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk);
    #1;
    t_reset();
    t_write_read();
    t_byte_en();
    t_priority();
    t_window();
    t_4dw();
    t_unmapped();
    t_drop();
    t_backpressure();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule